// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block collects every interrupt source of a multi-stream audio controller into one 32-bit global status word and turns that word into the controller's interrupt output. Each stream engine reports a buffer-completion flag. The command/response logic reports a response-interrupt flag and an overrun flag. The codec link reports per-codec state-change bits, each qualified by a wake-enable bit. An interrupt control register held here selects which collected sources may raise the global bit. It also carries the master enable in its top bit.

The status word is a snapshot, not a live view. It is rebuilt only when the surrounding register file signals that a source register was written, or when the control register itself is written. Software clears status bits by writing ones. The output runs in one of two modes, chosen by a mode input. In level mode it drives a level line. In message mode it emits a single-cycle notification pulse each time the interrupt condition rises.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status word, the control word, the level output and the pulse output are all zero.
- R2: When the status is rebuilt, status bit i (0 <= i < N_STREAMS) equals the buffer-completion flag of stream i.
- R3: When the status is rebuilt, status bit 30 is set if the response-interrupt flag is set, or the overrun flag is set, or any codec state-change bit is set together with its wake-enable bit.
- R4: When the status is rebuilt, status bit 31 is set exactly when the rebuilt bits 30..0 ANDed with control bits 30..0 are nonzero. A control write in the same cycle takes effect with its new value.
- R5: The status is rebuilt only on a cycle with `src_upd` or `ctl_we` high. Source changes at any other time leave `sts_out` unchanged.
- R6: A clear write (`clr_we`) without a rebuild in the same cycle clears every status bit that is set in `clr_data` and lies in the writable set {31, 30, N_STREAMS-1..0}. With 8 streams this set is 0xC00000FF. All other status bits keep their value.
- R7: When a clear write and a rebuild fall in the same cycle, the rebuilt value is stored and the clear has no effect.
- R8: In level mode (`msg_mode` = 0), `irq_level` equals status bit 31 AND control bit 31, and `msg_pulse` stays low.
- R9: In message mode (`msg_mode` = 1), `irq_level` stays low. `msg_pulse` is high for exactly one cycle, in the first cycle in which status bit 31 AND control bit 31 holds after a cycle in which it did not.
- R10: A control write stores `ctl_data` masked to bits {31, 30, N_STREAMS-1..0}. All other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe (also rebuilds the status) |
| ctl_data | input | 32 | Control register write data |
| clr_we | input | 1 | Status write-one-to-clear strobe |
| clr_data | input | 32 | Bits to clear in the status word |
| src_upd | input | 1 | A source register was written: rebuild the status |
| ring_irq | input | 1 | Response-ring interrupt flag |
| ring_ovr | input | 1 | Response-ring overrun flag |
| codec_chg | input | N_CODECS | Codec state-change bits |
| codec_wake | input | N_CODECS | Wake enable per codec |
| strm_done | input | N_STREAMS | Buffer-completion flag per stream |
| msg_mode | input | 1 | 1: message pulse output, 0: level output |
| sts_out | output | 32 | Global status word |
| ctl_out | output | 32 | Interrupt control word |
| irq_level | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle message notification |

## Verification
Two functions can land on the same clock edge: a software clear of the status and a rebuild caused by a source or control write. The bench provokes this by raising `clr_we` together with `src_upd`, and again with `ctl_we`, while a clear mask covers bits that the rebuild sets. It judges the result by requiring the rebuilt word in `sts_out`, with no bits missing. A second overlap is a control write that enables the master bit in the same cycle as the rebuild. In message mode this must yield exactly one pulse, one cycle after the edge, followed by a low cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int STS_W      = 32;
   localparam int GLOBAL_BIT = 31;
   localparam int CTRL_BIT   = 30;

   // writable / meaningful bits: master, controller source, one per stream
   function automatic logic [STS_W-1:0] live_mask(input int n_streams);
      logic [STS_W-1:0] m;
      m = '0;
      for (int i = 0; i < n_streams; i++) m[i] = 1'b1;
      m[CTRL_BIT]   = 1'b1;
      m[GLOBAL_BIT] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/irqagg_src.sv
module irqagg_src #(
   parameter int N_STREAMS = 8,
   parameter int N_CODECS  = 15
) (
   input  logic                 ring_irq,
   input  logic                 ring_ovr,
   input  logic [N_CODECS-1:0]  codec_chg,
   input  logic [N_CODECS-1:0]  codec_wake,
   input  logic [N_STREAMS-1:0] strm_done,
   output logic [31:0]          src_vec
);
   import irqagg_pkg::*;

   logic [N_CODECS-1:0] woken;
   logic                ctrl_src;

   assign woken    = codec_chg & codec_wake;
   assign ctrl_src = ring_irq | ring_ovr | (|woken);

   genvar g;
   generate
      for (g = 0; g < STS_W; g++) begin : g_bit
         if (g < N_STREAMS) begin : g_strm
            assign src_vec[g] = strm_done[g];
         end else if (g == CTRL_BIT) begin : g_ctrl
            assign src_vec[g] = ctrl_src;
         end else begin : g_zero
            assign src_vec[g] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs #(
   parameter int N_STREAMS = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_we,
   input  logic [31:0] ctl_data,
   input  logic        clr_we,
   input  logic [31:0] clr_data,
   input  logic        src_upd,
   input  logic [31:0] src_vec,
   output logic [31:0] sts_q,
   output logic [31:0] ctl_q
);
   import irqagg_pkg::*;
   localparam logic [31:0] LIVE = live_mask(N_STREAMS);

   logic        rebuild;
   logic [31:0] ctl_next;
   logic [31:0] fresh;
   logic        global_hit;

   assign rebuild    = src_upd | ctl_we;
   assign ctl_next   = ctl_we ? (ctl_data & LIVE) : ctl_q;
   assign global_hit = |(src_vec[CTRL_BIT:0] & ctl_next[CTRL_BIT:0]);

   always_comb begin
      fresh             = src_vec & LIVE;
      fresh[GLOBAL_BIT] = global_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         sts_q <= '0;
      end else begin
         ctl_q <= ctl_next;
         if (rebuild)
            sts_q <= fresh;
         else if (clr_we)
            sts_q <= sts_q & ~(clr_data & LIVE);
      end
   end

   // R6
   clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !rebuild) |=> ((sts_q & $past(clr_data & LIVE)) == 32'd0));
   // R4
   global_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rebuild |=> (sts_q[GLOBAL_BIT] == (|(sts_q[CTRL_BIT:0] & ctl_q[CTRL_BIT:0]))));
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rebuild && !clr_we) |=> $stable(sts_q));
endmodule

// File: rtl/irqagg_out.sv
module irqagg_out #(
   parameter bit MSG_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sts_global,
   input  logic ctl_master,
   input  logic msg_mode,
   output logic irq_level,
   output logic msg_pulse
);
   logic cond;
   logic cond_q;

   assign cond = sts_global & ctl_master;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   generate
      if (MSG_SUPPORT) begin : g_dual
         assign irq_level = cond & ~msg_mode;
         assign msg_pulse = cond & ~cond_q & msg_mode;
      end else begin : g_level_only
         assign irq_level = cond;
         assign msg_pulse = 1'b0;
      end
   endgenerate

   // R8
   level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_level |-> (sts_global && ctl_master));
   // R9
   pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |=> !msg_pulse);
   // R9
   msg_no_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_mode && MSG_SUPPORT) |-> !irq_level);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int N_STREAMS   = 8,
   parameter int N_CODECS    = 15,
   parameter bit MSG_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [31:0]          ctl_data,
   input  logic                 clr_we,
   input  logic [31:0]          clr_data,
   input  logic                 src_upd,
   input  logic                 ring_irq,
   input  logic                 ring_ovr,
   input  logic [N_CODECS-1:0]  codec_chg,
   input  logic [N_CODECS-1:0]  codec_wake,
   input  logic [N_STREAMS-1:0] strm_done,
   input  logic                 msg_mode,
   output logic [31:0]          sts_out,
   output logic [31:0]          ctl_out,
   output logic                 irq_level,
   output logic                 msg_pulse
);
   import irqagg_pkg::*;

   generate
      if (N_STREAMS < 1 || N_STREAMS > CTRL_BIT) begin : g_bad_streams
         $error("N_STREAMS must lie in 1..30");
      end
      if (N_CODECS < 1 || N_CODECS > 16) begin : g_bad_codecs
         $error("N_CODECS must lie in 1..16");
      end
   endgenerate

   logic [31:0] src_vec;

   irqagg_src #(.N_STREAMS(N_STREAMS), .N_CODECS(N_CODECS)) u_src (
      .ring_irq   (ring_irq),
      .ring_ovr   (ring_ovr),
      .codec_chg  (codec_chg),
      .codec_wake (codec_wake),
      .strm_done  (strm_done),
      .src_vec    (src_vec)
   );

   irqagg_regs #(.N_STREAMS(N_STREAMS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .ctl_data (ctl_data),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .src_upd  (src_upd),
      .src_vec  (src_vec),
      .sts_q    (sts_out),
      .ctl_q    (ctl_out)
   );

   irqagg_out #(.MSG_SUPPORT(MSG_SUPPORT)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .sts_global (sts_out[GLOBAL_BIT]),
      .ctl_master (ctl_out[GLOBAL_BIT]),
      .msg_mode   (msg_mode),
      .irq_level  (irq_level),
      .msg_pulse  (msg_pulse)
   );
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
   localparam int NS = 8;
   localparam int NC = 15;
   localparam logic [31:0] LIVE = 32'hC00000FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_we = 0, clr_we = 0, src_upd = 0;
   logic [31:0] ctl_data = 0, clr_data = 0;
   logic ring_irq = 0, ring_ovr = 0, msg_mode = 0;
   logic [NC-1:0] codec_chg = 0, codec_wake = 0;
   logic [NS-1:0] strm_done = 0;
   logic [31:0] sts_out, ctl_out;
   logic irq_level, msg_pulse;

   int checks = 0, errors = 0;
   logic [31:0] e_sts = 0, e_ctl = 0;
   logic prev_cond = 0;

   always #10 clk = ~clk;

   irq_aggregator #(.N_STREAMS(NS), .N_CODECS(NC)) dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rebuilt(input logic [31:0] c);
      logic [31:0] s;
      s = 32'(strm_done);
      s[30] = ring_irq | ring_ovr | (|(codec_chg & codec_wake));
      s[31] = |(s[30:0] & c[30:0]);
      return s;
   endfunction

   // one clock: drive at negedge, check at following negedge
   task automatic step(input string tag, input logic upd, input logic cwr,
                       input logic [31:0] cdat, input logic clr, input logic [31:0] kdat);
      logic cond;
      src_upd = upd; ctl_we = cwr; ctl_data = cdat; clr_we = clr; clr_data = kdat;
      if (cwr) e_ctl = cdat & LIVE;
      if (upd || cwr) e_sts = rebuilt(e_ctl);
      else if (clr) e_sts = e_sts & ~(kdat & LIVE);
      @(negedge clk);
      src_upd = 0; ctl_we = 0; clr_we = 0;
      cond = e_sts[31] & e_ctl[31];
      chk({tag, " status"}, sts_out, e_sts);
      chk({tag, " control"}, ctl_out, e_ctl);
      chk({tag, " level"}, 32'(irq_level), 32'(cond & ~msg_mode));
      chk({tag, " pulse"}, 32'(msg_pulse), 32'(cond & ~prev_cond & msg_mode));
      prev_cond = cond;
   endtask

   initial begin
      #3_000_000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", sts_out, 0);
      chk("R1 control", ctl_out, 0);
      chk("R1 level", 32'(irq_level), 0);
      chk("R1 pulse", 32'(msg_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 control mask
      step("R10 all ones", 0, 1, 32'hFFFF_FFFF, 0, 0);
      step("R10 clear", 0, 1, 32'h3FFF_FF00, 0, 0);

      // R2 R4 R8 stream sweep under several enable patterns
      for (int c = 0; c < 4; c++) begin
         logic [31:0] cw;
         cw = (c == 0) ? 32'h8000_00FF : (c == 1) ? 32'h8000_000F :
              (c == 2) ? 32'h8000_00A5 : 32'h0000_00FF;
         step("R10 R4 ctl", 0, 1, cw, 0, 0);
         for (int s = 0; s < 256; s++) begin
            strm_done = 8'(s);
            step("R2 R4 R8 stream", 1, 0, 0, 0, 0);
         end
      end
      strm_done = 0;

      // R3 controller source sweep
      step("R3 ctl", 0, 1, 32'hC000_0000, 0, 0);
      for (int v = 0; v < 1024; v++) begin
         ring_irq = v[8]; ring_ovr = v[9];
         codec_chg = NC'(v[3:0]); codec_wake = NC'(v[7:4]);
         step("R3 ctrl src", 1, 0, 0, 0, 0);
      end
      codec_chg = NC'(15'h4000); codec_wake = NC'(15'h4000); ring_irq = 0; ring_ovr = 0;
      step("R3 top codec", 1, 0, 0, 0, 0);

      // R5 source changes without rebuild are ignored
      strm_done = 8'h3C; codec_chg = 0;
      step("R5 idle", 0, 0, 0, 0, 0);
      step("R5 idle2", 0, 0, 0, 0, 0);
      step("R5 rebuild", 1, 0, 0, 0, 0);

      // R6 write-one-to-clear
      step("R6 ctl", 0, 1, 32'hC000_00FF, 0, 0);
      strm_done = 8'hFF; ring_ovr = 1;
      step("R6 fill", 1, 0, 0, 0, 0);
      step("R6 clr low", 0, 0, 0, 1, 32'h0000_000F);
      step("R6 clr unmasked", 0, 0, 0, 1, 32'h3FFF_FF00);
      step("R6 clr top", 0, 0, 0, 1, 32'hC000_0000);
      step("R6 clr all", 0, 0, 0, 1, 32'hFFFF_FFFF);

      // R7 collision of clear with rebuild
      step("R7 clr+upd", 1, 0, 0, 1, 32'hFFFF_FFFF);
      step("R7 clr+ctl", 0, 1, 32'h8000_00FF, 1, 32'hFFFF_FFFF);

      // R9 message mode pulses
      msg_mode = 1;
      step("R9 off", 0, 1, 32'h0000_00FF, 0, 0);
      step("R9 rise", 0, 1, 32'h8000_00FF, 0, 0);
      step("R9 hold", 0, 0, 0, 0, 0);
      step("R9 hold2", 1, 0, 0, 0, 0);
      step("R9 drop", 0, 0, 0, 1, 32'h8000_0000);
      step("R9 rise2", 1, 0, 0, 0, 0);
      step("R9 after", 0, 0, 0, 0, 0);
      msg_mode = 0;
      step("R8 back to level", 0, 0, 0, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule